// File: doc/BRIEF.md
# Disabled-Group Byte Compactor

This block sits in a capture datapath. Each sample word is split into equal channel groups, one byte lane per group, and the user may switch any of these groups off for a capture. A switched-off group would otherwise leave an empty lane in every stored word. The compactor removes those lanes. It moves the remaining groups down into the lowest lanes and keeps their original relative order, so that later storage and serial transfer stages see one unbroken run of valid bytes.

Alongside the packed word, the block reports how many lanes carry data. Its outputs are registered, so results appear one clock after the input is presented. The input valid flag is delayed by the same amount. The group-off mask is expected to stay constant for the whole of a capture.

Top module: `grp_pack_top`

## Requirements
- R1: Every enabled group appears in the output, and enabled groups fill output lanes 0, 1, 2, … in ascending order of their input group index. Group g occupies input bits [8g+7:8g] and output lane k occupies bits [8k+7:8k].
- R2: With `grp_off` = 4'b0101 (groups 0 and 2 off), output lane 0 holds input group 1 and output lane 1 holds input group 3.
- R3: Output lanes at or above the enabled-group count are zero, so bytes of disabled groups never reach the output.
- R4: `out_count` equals the number of zero bits in `grp_off`, a value from 0 to 4.
- R5: `out_data` and `out_count` reflect the inputs sampled at the previous rising clock edge, which is exactly one cycle of latency.
- R6: `out_valid` is `in_valid` delayed by one cycle, but stays low whenever the sampled `grp_off` is all ones.
- R7: While `rst` is high at a rising edge, the following cycle shows `out_valid`, `out_count` and `out_data` at zero.
- R8: With `grp_off` = 4'b0000 the output word equals the input word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_data | input | 32 | Raw sample, four 8-bit groups |
| grp_off | input | 4 | Bit g set disables group g |
| out_valid | output | 1 | Packed sample is valid |
| out_data | output | 32 | Packed sample, enabled groups in the low lanes |
| out_count | output | 3 | Number of enabled groups (valid bytes) |

## Verification
A wrong rank computed for one group sends its byte to the wrong lane or leaves a hole. The first word after that mask is applied shows the error at `out_data`, one clock after the input. A wrong population count appears at `out_count` on the same cycle, and it also breaks the zero-lane pattern above the count. A fault in the valid path appears either as a valid pulse in the wrong cycle or as a pulse while every group is off.

// File: rtl/grp_pack_pkg.sv
package grp_pack_pkg;
  parameter int unsigned GRP_W_DEF   = 8;
  parameter int unsigned NUM_GRP_DEF = 4;
endpackage

// File: rtl/grp_pack_rank.sv
module grp_pack_rank #(
  parameter int unsigned NUM_GRP = 4,
  localparam int unsigned IDX_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int unsigned CNT_W  = $clog2(NUM_GRP + 1)
) (
  input  logic [NUM_GRP-1:0]            grp_en,
  output logic [NUM_GRP-1:0][IDX_W-1:0] grp_rank,
  output logic [CNT_W-1:0]              en_total
);
  logic [CNT_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      grp_rank[g] = acc[IDX_W-1:0];
      acc = acc + CNT_W'(grp_en[g]);
    end
    en_total = acc;
  end
endmodule

// File: rtl/grp_pack_route.sv
module grp_pack_route #(
  parameter int unsigned GRP_W   = 8,
  parameter int unsigned NUM_GRP = 4,
  localparam int unsigned IDX_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic [NUM_GRP-1:0][GRP_W-1:0] lanes_in,
  input  logic [NUM_GRP-1:0]            grp_en,
  input  logic [NUM_GRP-1:0][IDX_W-1:0] grp_rank,
  output logic [NUM_GRP-1:0][GRP_W-1:0] lanes_out
);
  for (genvar k = 0; k < NUM_GRP; k++) begin : g_lane
    always_comb begin
      lanes_out[k] = '0;
      for (int g = k; g < NUM_GRP; g++) begin
        if (grp_en[g] && (grp_rank[g] == IDX_W'(k)))
          lanes_out[k] = lanes_out[k] | lanes_in[g];
      end
    end
  end
endmodule

// File: rtl/grp_pack_oreg.sv
module grp_pack_oreg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nxt_valid,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic [CNT_W-1:0]  nxt_count,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic [CNT_W-1:0]  q_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_count <= '0;
    end else begin
      q_valid <= nxt_valid;
      q_data  <= nxt_data;
      q_count <= nxt_count;
    end
  end
endmodule

// File: rtl/grp_pack_top.sv
module grp_pack_top #(
  parameter int unsigned GRP_W   = grp_pack_pkg::GRP_W_DEF,
  parameter int unsigned NUM_GRP = grp_pack_pkg::NUM_GRP_DEF,
  localparam int unsigned DATA_W = GRP_W * NUM_GRP,
  localparam int unsigned IDX_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int unsigned CNT_W  = $clog2(NUM_GRP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [NUM_GRP-1:0] grp_off,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic [CNT_W-1:0]   out_count
);
  logic [NUM_GRP-1:0]            grp_en;
  logic [NUM_GRP-1:0][IDX_W-1:0] grp_rank;
  logic [CNT_W-1:0]              en_total;
  logic [NUM_GRP-1:0][GRP_W-1:0] lanes_in;
  logic [NUM_GRP-1:0][GRP_W-1:0] lanes_out;
  logic                          nxt_valid;

  assign grp_en   = ~grp_off;
  assign lanes_in = in_data;

  grp_pack_rank #(.NUM_GRP(NUM_GRP)) rank_i (
    .grp_en   (grp_en),
    .grp_rank (grp_rank),
    .en_total (en_total)
  );

  grp_pack_route #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) route_i (
    .lanes_in  (lanes_in),
    .grp_en    (grp_en),
    .grp_rank  (grp_rank),
    .lanes_out (lanes_out)
  );

  assign nxt_valid = in_valid && (en_total != '0);

  grp_pack_oreg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) oreg_i (
    .clk       (clk),
    .rst       (rst),
    .nxt_valid (nxt_valid),
    .nxt_data  (lanes_out),
    .nxt_count (en_total),
    .q_valid   (out_valid),
    .q_data    (out_data),
    .q_count   (out_count)
  );
endmodule

// File: rtl/grp_pack_chk.sv
module grp_pack_chk #(
  parameter int unsigned GRP_W   = 8,
  parameter int unsigned NUM_GRP = 4,
  localparam int unsigned DATA_W = GRP_W * NUM_GRP,
  localparam int unsigned CNT_W  = $clog2(NUM_GRP + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [DATA_W-1:0]  in_data,
  input logic [NUM_GRP-1:0] grp_off,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_data,
  input logic [CNT_W-1:0]   out_count
);
  logic [DATA_W-1:0] keep;

  always_comb begin
    for (int k = 0; k < NUM_GRP; k++)
      keep[k*GRP_W +: GRP_W] = (CNT_W'(k) < out_count) ? {GRP_W{1'b1}} : {GRP_W{1'b0}};
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(&grp_off)) |=> out_valid); // R6
  AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&grp_off) |=> (!out_valid && out_count == '0 && out_data == '0)); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R6
  AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_count == CNT_W'($countones(~$past(grp_off))))); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((out_data & ~keep) == '0)); // R3
  AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
    (grp_off == '0) |=> (out_data == $past(in_data))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_count == '0 && out_data == '0)); // R7
endmodule

bind grp_pack_top grp_pack_chk #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .grp_off   (grp_off),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_count (out_count)
);

// File: tb/grp_pack_top_tb_top.sv
module grp_pack_top_tb_top;
  localparam int W = 8;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [3:0]  grp_off = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [2:0]  out_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        exp_v;
  logic [31:0] exp_d;
  logic [2:0]  exp_c;
  logic [3:0]  exp_off;
  bit          exp_rst;
  bit          have_exp = 1'b0;

  always #4 clk = ~clk;

  grp_pack_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .grp_off(grp_off), .out_valid(out_valid), .out_data(out_data),
    .out_count(out_count)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model: walk groups in order, append enabled ones to a queue.
  task automatic model();
    byte unsigned q[$];
    q = {};
    for (int g = 0; g < N; g++)
      if (!grp_off[g]) q.push_back(in_data[g*W +: W]);
    exp_rst = rst;
    exp_off = grp_off;
    if (rst) begin
      exp_v = 1'b0; exp_d = '0; exp_c = '0;
    end else begin
      exp_c = 3'(q.size());
      exp_d = '0;
      for (int k = 0; k < q.size(); k++) exp_d[k*W +: W] = q[k];
      exp_v = in_valid && (q.size() != 0);
    end
    have_exp = 1'b1;
  endtask

  task automatic compare();
    logic [31:0] lowm;
    string rl;
    if (!have_exp) return;
    lowm = '0;
    for (int k = 0; k < N; k++) if (k < int'(exp_c)) lowm[k*W +: W] = 8'hFF;
    if (exp_rst) begin
      chk(out_valid === 1'b0 && out_data === '0 && out_count === '0, "R7 reset clear",
          {out_valid, out_count, out_data[27:0]}, 32'h0);
      return;
    end
    if (exp_off == 4'b0101) rl = "R2 groups 1,3 to lanes 0,1";
    else if (exp_off == 4'b0000) rl = "R8 full pass";
    else rl = "R1 order with R5 latency";
    chk((out_data & lowm) === (exp_d & lowm), rl, out_data & lowm, exp_d & lowm);
    chk((out_data & ~lowm) === 32'h0, "R3 upper lanes zero", out_data & ~lowm, 32'h0);
    chk(out_count === exp_c, "R4 count", 32'(out_count), 32'(exp_c));
    chk(out_valid === exp_v, "R6 valid", 32'(out_valid), 32'(exp_v));
  endtask

  task automatic step(input bit r, input bit v, input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    compare();
    rst = r; in_valid = v; grp_off = off; in_data = d;
    model();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R7: reset cycles
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 4'h0, 32'hDEADBEEF);
    // R2: documented case
    step(1'b0, 1'b1, 4'b0101, 32'h44332211);
    step(1'b0, 1'b1, 4'b0101, 32'hA1B2C3D4);
    // R8: all enabled
    step(1'b0, 1'b1, 4'b0000, 32'h12345678);
    // all masks, several patterns, valid toggling
    for (int m = 0; m < 16; m++) begin
      step(1'b0, 1'b1, 4'(m), 32'h04030201);
      step(1'b0, 1'b0, 4'(m), 32'hFFEEDDCC);
      step(1'b0, 1'b1, 4'(m), 32'h80FF017F);
    end
    // R6: all groups off with valid high
    step(1'b0, 1'b1, 4'hF, 32'hCAFEF00D);
    step(1'b0, 1'b1, 4'hF, 32'h0);
    // R5: data changing every cycle under a steady mask
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 4'b1010, 32'(i * 32'h01010101 + 32'h10203040));
    // reset in the middle of traffic
    step(1'b1, 1'b1, 4'b0011, 32'h55AA55AA);
    step(1'b0, 1'b1, 4'b0011, 32'h55AA55AA);
    // random traffic
    for (int i = 0; i < 600; i++)
      step(1'b0, 1'($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)), 32'($urandom()));
    step(1'b0, 1'b0, 4'h0, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule